// File: doc/BRIEF.md
# Video Scroll and Address Register File

This block is the register file that a host processor sees when it talks to a tile-based video processor. The host presents an address, a data byte and a one-cycle read or write strobe. Only the low three address bits choose one of eight byte-wide registers. The block keeps these values:

- control and mask bytes;
- a status byte;
- a 15-bit staging ("temporary") address and a 15-bit live ("current") address;
- a 3-bit fine horizontal scroll;
- a sprite-memory pointer with its 256-byte sprite attribute store;
- a latch that holds the last byte moved over the bus.

Two registers take their bytes in pairs and share one first/second toggle. The scroll register and the address register both spread their data bits into fixed fields of the staging address. A status read returns that toggle to the first-write state.

The current address goes to a separate data-port block. Register 7 is the data port. Every access to it raises a combinational access pulse toward that block, and on the same clock edge the current address advances by 1 or by 32. Status bits are loaded through a test input, because the renderer that would normally set them is not part of this block.

Top module: `vid_regfile`

## Requirements
- R1: Only `bus_addr[2:0]` selects the register, so the eight registers repeat every eight addresses; the upper address bits have no effect.
- R2: A write to register 0 stores the byte on `ctrl_q` and copies data bits 1:0 into `tmp_addr[11:10]`, leaving the other staging bits unchanged. A write to register 1 stores the byte on `mask_q`.
- R3: A write to register 5 with the toggle clear loads `fine_x` from data bits 2:0 and `tmp_addr[4:0]` from data bits 7:3, then sets the toggle.
- R4: A write to register 5 with the toggle set loads `tmp_addr[14:12]` from data bits 2:0 and `tmp_addr[9:5]` from data bits 7:3, then clears the toggle.
- R5: A write to register 6 with the toggle clear loads `tmp_addr[13:8]` from data bits 5:0 and clears `tmp_addr[14]`, keeps `tmp_addr[7:0]`, then sets the toggle.
- R6: A write to register 6 with the toggle set replaces `tmp_addr[7:0]` with the data and loads the whole resulting staging address into `cur_addr` on the same edge, then clears the toggle.
- R7: A read of register 2 returns the status byte, then clears status bit 7 and clears the toggle. A pulse on `stat_load` loads `stat_din` into the status byte.
- R8: A write to register 3 sets the sprite pointer. A write to register 4 stores the byte at the pointer and advances the pointer, with 255 wrapping to 0. A read of register 4 returns the byte at the pointer and leaves the pointer unchanged.
- R9: `bus_rdata` is the bus latch. From the edge that ends a strobe, it holds the byte just written, or the byte just read. A read of registers 0, 1, 3, 5 or 6 leaves it unchanged.
- R10: During a strobe on register 7, `dport_acc` is 1, and `dport_we` equals the write strobe. A read of register 7 returns `dport_rdata`.
- R11: Every register 7 access adds 32 to `cur_addr` when control bit 2 is 1, and 1 when it is 0, modulo 2^15.
- R12: After reset, `ctrl_q`, `mask_q`, `tmp_addr`, `cur_addr`, `fine_x`, `bus_rdata`, the toggle, the status byte and the sprite pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | BUS_AW (16) | Host address; only bits 2:0 are decoded |
| bus_wdata | input | 8 | Host write data |
| bus_we | input | 1 | One-cycle write strobe |
| bus_re | input | 1 | One-cycle read strobe (ignored if `bus_we` is also high) |
| bus_rdata | output | 8 | Bus latch: the last byte transferred |
| stat_load | input | 1 | Test load of the status byte |
| stat_din | input | 8 | Status value for `stat_load` |
| dport_rdata | input | 8 | Read data from the data-port block |
| dport_acc | output | 1 | Data-port access in this cycle |
| dport_we | output | 1 | The data-port access is a write |
| ctrl_q | output | 8 | Control byte |
| mask_q | output | 8 | Mask byte |
| tmp_addr | output | 15 | Staging address |
| cur_addr | output | 15 | Current address for the data port |
| fine_x | output | 3 | Fine horizontal scroll |

## Verification
The hardest state to reach from the ports is a toggle that is out of step with what the host expects. Registers 5 and 6 share the toggle, and the toggle itself cannot be seen at the ports. The vector table therefore interleaves writes to the two registers, and inserts a status read between two halves of a pair. The bench then checks the staging address and `fine_x`, which show whether the next write was taken as a first write or a second one. A separate directed test writes one scroll byte, reads the status register, and writes again. It then checks that `fine_x` took the second value, which only happens if the read cleared the toggle. The sprite pointer is driven from 254 across the wrap to 1, and two reads in a row confirm that a read does not advance it.

// File: rtl/vr_pkg.sv
// Package: shared register indices and field constants for the video
// register file. Assumes an 8-bit host data bus.
package vr_pkg;
    localparam int VR_DW = 8;      // host data width
    localparam int VR_AW = 15;     // staging/current address width
    localparam int VR_FX = 3;      // fine scroll width
    localparam int VR_BIG_STEP = 32;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_MASK = 3'd1,
        REG_STAT = 3'd2,
        REG_SPTR = 3'd3,
        REG_SDAT = 3'd4,
        REG_SCRL = 3'd5,
        REG_ADDR = 3'd6,
        REG_DATA = 3'd7
    } vr_reg_e;
endpackage

// File: rtl/vr_scroll.sv
// Module: vr_scroll
// Holds the staging address, current address, fine scroll and the shared
// first/second write toggle. Assumes at most one of wr_ctrl, wr_scrl,
// wr_addr and step is high in any cycle (a single register is selected).
module vr_scroll
    import vr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_scrl,
    input  logic             wr_addr,
    input  logic             clr_tog,
    input  logic             step,
    input  logic             step_big,
    input  logic [VR_DW-1:0] din,
    output logic [VR_AW-1:0] tmp_addr,
    output logic [VR_AW-1:0] cur_addr,
    output logic [VR_FX-1:0] fine_x,
    output logic             toggle
);
    localparam logic [VR_AW-1:0] STEP_BIG = VR_AW'(VR_BIG_STEP);
    localparam logic [VR_AW-1:0] STEP_ONE = VR_AW'(1);

    logic [VR_AW-1:0] step_amt;

    // Purpose: choose the data-port advance amount from control bit 2.
    always_comb begin
        step_amt = step_big ? STEP_BIG : STEP_ONE;
    end

    // Purpose: update the address fields, fine scroll and toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_addr <= '0;
            cur_addr <= '0;
            fine_x   <= '0;
            toggle   <= 1'b0;
        end else begin
            if (clr_tog) begin
                toggle <= 1'b0;
            end
            if (wr_ctrl) begin
                tmp_addr[11:10] <= din[1:0];
            end else if (wr_scrl) begin
                if (!toggle) begin
                    fine_x        <= din[2:0];
                    tmp_addr[4:0] <= din[7:3];
                    toggle        <= 1'b1;
                end else begin
                    tmp_addr[14:12] <= din[2:0];
                    tmp_addr[9:5]   <= din[7:3];
                    toggle          <= 1'b0;
                end
            end else if (wr_addr) begin
                if (!toggle) begin
                    tmp_addr[14]   <= 1'b0;
                    tmp_addr[13:8] <= din[5:0];
                    toggle         <= 1'b1;
                end else begin
                    tmp_addr[7:0] <= din;
                    cur_addr      <= {tmp_addr[14:8], din};
                    toggle        <= 1'b0;
                end
            end
            if (step) begin
                cur_addr <= cur_addr + step_amt;
            end
        end
    end
endmodule

// File: rtl/vr_sprite.sv
// Module: vr_sprite
// Sprite attribute store with an auto-advancing pointer. Assumes
// SPR_AW <= 8, so the pointer is loaded from the low bits of the data byte.
module vr_sprite
    import vr_pkg::*;
#(
    parameter int SPR_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic              dat_wr,
    input  logic [VR_DW-1:0]  din,
    output logic [VR_DW-1:0]  rd_data,
    output logic [SPR_AW-1:0] ptr
);
    localparam int DEPTH = 1 << SPR_AW;

    logic [VR_DW-1:0] mem [DEPTH];

    // Purpose: load or advance the pointer; it wraps at the store depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_wr) begin
            ptr <= din[SPR_AW-1:0];
        end else if (dat_wr) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Purpose: store a data byte at the current pointer.
    always_ff @(posedge clk) begin
        if (dat_wr) begin
            mem[ptr] <= din;
        end
    end

    // Purpose: present the byte at the pointer for host reads.
    always_comb begin
        rd_data = mem[ptr];
    end
endmodule

// File: rtl/vid_regfile.sv
// Module: vid_regfile
// Host-facing register file of the video processor. Decodes bus_addr[2:0],
// holds the control, mask and status bytes and the bus latch, and drives
// the scroll/address unit and the sprite store. Assumes one-cycle strobes.
// If bus_we and bus_re are high together, the access is taken as a write.
module vid_regfile
    import vr_pkg::*;
#(
    parameter int BUS_AW = 16,
    parameter int SPR_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [VR_DW-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [VR_DW-1:0]  bus_rdata,
    input  logic              stat_load,
    input  logic [VR_DW-1:0]  stat_din,
    input  logic [VR_DW-1:0]  dport_rdata,
    output logic              dport_acc,
    output logic              dport_we,
    output logic [VR_DW-1:0]  ctrl_q,
    output logic [VR_DW-1:0]  mask_q,
    output logic [VR_AW-1:0]  tmp_addr,
    output logic [VR_AW-1:0]  cur_addr,
    output logic [VR_FX-1:0]  fine_x
);
    vr_reg_e          regsel;
    logic             rd_en;
    logic [7:0]       wr_hit;
    logic [7:0]       rd_hit;
    logic [VR_DW-1:0] status_q;
    logic [VR_DW-1:0] latch_q;
    logic [VR_DW-1:0] spr_rd;
    logic [SPR_AW-1:0] spr_ptr;
    logic             wr_tog;

    // Purpose: decode the mirrored register select into hit vectors.
    always_comb begin
        regsel = vr_reg_e'(bus_addr[2:0]);
        rd_en  = bus_re && !bus_we;
    end

    for (genvar g = 0; g < 8; g++) begin : g_dec
        assign wr_hit[g] = bus_we && (regsel == vr_reg_e'(g));
        assign rd_hit[g] = rd_en  && (regsel == vr_reg_e'(g));
    end

    assign dport_acc = wr_hit[REG_DATA] || rd_hit[REG_DATA];
    assign dport_we  = wr_hit[REG_DATA];
    assign bus_rdata = latch_q;

    // Purpose: hold the control and mask bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_hit[REG_CTRL]) ctrl_q <= bus_wdata;
            if (wr_hit[REG_MASK]) mask_q <= bus_wdata;
        end
    end

    // Purpose: status byte; a test load wins over the clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (stat_load) begin
            status_q <= stat_din;
        end else if (rd_hit[REG_STAT]) begin
            status_q[7] <= 1'b0;
        end
    end

    // Purpose: bus latch captures each transferred byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (bus_we) begin
            latch_q <= bus_wdata;
        end else if (rd_en) begin
            case (regsel)
                REG_STAT: latch_q <= status_q;
                REG_SDAT: latch_q <= spr_rd;
                REG_DATA: latch_q <= dport_rdata;
                default:  latch_q <= latch_q;
            endcase
        end
    end

    vr_scroll u_scroll (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_hit[REG_CTRL]),
        .wr_scrl  (wr_hit[REG_SCRL]),
        .wr_addr  (wr_hit[REG_ADDR]),
        .clr_tog  (rd_hit[REG_STAT]),
        .step     (dport_acc),
        .step_big (ctrl_q[2]),
        .din      (bus_wdata),
        .tmp_addr (tmp_addr),
        .cur_addr (cur_addr),
        .fine_x   (fine_x),
        .toggle   (wr_tog)
    );

    vr_sprite #(.SPR_AW(SPR_AW)) u_sprite (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_wr  (wr_hit[REG_SPTR]),
        .dat_wr  (wr_hit[REG_SDAT]),
        .din     (bus_wdata),
        .rd_data (spr_rd),
        .ptr     (spr_ptr)
    );
endmodule

// File: rtl/vid_regfile_chk.sv
// Module: vid_regfile_chk
// Temporal checks on the register file, bound into vid_regfile. A flag
// that starts at the first clock after reset keeps $past within the
// cycles since reset.
module vid_regfile_chk #(
    parameter int SPR_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        sel,
    input logic              we,
    input logic              re,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [7:0]        status,
    input logic [SPR_AW-1:0] ptr,
    input logic              toggle,
    input logic [14:0]       tmp,
    input logic [14:0]       cur,
    input logic [7:0]        ctrl,
    input logic              acc
);
    logic pv;

    // Purpose: mark that one clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    // R9
    wr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(we) |-> rdata == $past(wdata));

    // R7
    stat_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(re && !we && sel == 3'd2) |-> rdata == $past(status));

    // R7
    stat_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(re && !we && sel == 3'd2) |-> !toggle);

    // R3
    scrl_tog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(we && sel == 3'd5) |-> toggle != $past(toggle));

    // R6
    addr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(we && sel == 3'd6 && toggle)
        |-> cur == {$past(tmp[14:8]), $past(wdata)});

    // R11
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(acc)
        |-> cur == $past(cur) + ($past(ctrl[2]) ? 15'd32 : 15'd1));

    // R8
    sprite_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(we && sel == 3'd4) |-> ptr == SPR_AW'($past(ptr) + 1'b1));
endmodule

bind vid_regfile vid_regfile_chk #(.SPR_AW(SPR_AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (bus_addr[2:0]),
    .we     (bus_we),
    .re     (bus_re),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .status (status_q),
    .ptr    (spr_ptr),
    .toggle (wr_tog),
    .tmp    (tmp_addr),
    .cur    (cur_addr),
    .ctrl   (ctrl_q),
    .acc    (dport_acc)
);

// File: tb/tb_vid_regfile.sv
// Bench for vid_regfile: a vector table walked by one loop, then directed
// tests for reset, status, toggle, the sprite pointer and the address step.
module tb_vid_regfile;
    localparam int CLK_NS = 10;
    localparam int NVEC   = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        stat_load = 1'b0;
    logic [7:0]  stat_din = '0;
    logic [7:0]  dport_rdata = 8'hC3;
    logic        dport_acc;
    logic        dport_we;
    logic [7:0]  ctrl_q;
    logic [7:0]  mask_q;
    logic [14:0] tmp_addr;
    logic [14:0] cur_addr;
    logic [2:0]  fine_x;

    int n_chk = 0;
    int n_bad = 0;
    logic cap_acc;
    logic cap_we;
    logic done = 1'b0;

    vid_regfile dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .stat_load(stat_load), .stat_din(stat_din), .dport_rdata(dport_rdata),
        .dport_acc(dport_acc), .dport_we(dport_we), .ctrl_q(ctrl_q),
        .mask_q(mask_q), .tmp_addr(tmp_addr), .cur_addr(cur_addr),
        .fine_x(fine_x)
    );

    always #(CLK_NS/2) clk = ~clk;

    // {req[3:0], wr, addr[15:0], data[7:0], exp_tmp[14:0], exp_cur[14:0], exp_rd[7:0]}
    localparam logic [66:0] VEC [NVEC] = '{
        {4'd2,  1'b1, 16'h2000, 8'h03, 15'h0C00, 15'h0000, 8'h03}, // R2 ctrl -> tmp[11:10]
        {4'd3,  1'b1, 16'h2005, 8'hAD, 15'h0C15, 15'h0000, 8'hAD}, // R3 first scroll
        {4'd4,  1'b1, 16'h200D, 8'h5E, 15'h6D75, 15'h0000, 8'h5E}, // R4 second scroll, R1 mirror
        {4'd9,  1'b0, 16'h2001, 8'h00, 15'h6D75, 15'h0000, 8'h5E}, // R9 read write-only
        {4'd5,  1'b1, 16'h2006, 8'hFF, 15'h3F75, 15'h0000, 8'hFF}, // R5 clears bit 14
        {4'd7,  1'b0, 16'h3FFA, 8'h00, 15'h3F75, 15'h0000, 8'h00}, // R7 status, R1 mirror
        {4'd5,  1'b1, 16'h2006, 8'h12, 15'h1275, 15'h0000, 8'h12}, // R5 after toggle clear
        {4'd6,  1'b1, 16'h2006, 8'h34, 15'h1234, 15'h1234, 8'h34}, // R6 copy to current
        {4'd2,  1'b1, 16'h2000, 8'h00, 15'h1234, 15'h1234, 8'h00}, // R2
        {4'd11, 1'b1, 16'h2007, 8'h99, 15'h1234, 15'h1235, 8'h99}, // R11 step 1
        {4'd2,  1'b1, 16'h2000, 8'h04, 15'h1234, 15'h1235, 8'h04}, // R2 ctrl bit 2
        {4'd10, 1'b0, 16'h2007, 8'h00, 15'h1234, 15'h1255, 8'hC3}, // R10 read data port
        {4'd3,  1'b1, 16'h2005, 8'h07, 15'h1220, 15'h1255, 8'h07}, // R3
        {4'd7,  1'b0, 16'h2002, 8'h00, 15'h1220, 15'h1255, 8'h00}, // R7
        {4'd5,  1'b1, 16'h2006, 8'h7F, 15'h3F20, 15'h1255, 8'h7F}  // R5
    };

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = wr;
        bus_re    = !wr;
        #1;
        cap_acc = dport_acc;
        cap_we  = dport_we;
        @(negedge clk);
        bus_we = 1'b0;
        bus_re = 1'b0;
    endtask

    task automatic load_status(input logic [7:0] v);
        @(negedge clk);
        stat_load = 1'b1;
        stat_din  = v;
        @(negedge clk);
        stat_load = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 tmp_addr", int'(tmp_addr), 0);
        chk("R12 cur_addr", int'(cur_addr), 0);
        chk("R12 fine_x", int'(fine_x), 0);
        chk("R12 bus_rdata", int'(bus_rdata), 0);
        chk("R12 ctrl_q", int'(ctrl_q), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [66:0] v;
            string tag;
            v = VEC[i];
            bus_op(v[62], v[61:46], v[45:38]);
            tag = $sformatf("R%0d vec%0d", v[66:63], i);
            chk({tag, " tmp"}, int'(tmp_addr), int'(v[37:23]));
            chk({tag, " cur"}, int'(cur_addr), int'(v[22:8]));
            chk({tag, " rdata"}, int'(bus_rdata), int'(v[7:0]));
            if (i == 1)  chk("R3 fine_x", int'(fine_x), 5);
            if (i == 9)  chk("R10 acc/we on write", int'({cap_acc, cap_we}), 3);
            if (i == 11) chk("R10 acc/we on read", int'({cap_acc, cap_we}), 2);
            if (i == 12) chk("R3 fine_x", int'(fine_x), 7);
        end

        // R7 status load, read and bit-7 clear (toggle is set after vec14)
        load_status(8'hE0);
        bus_op(1'b0, 16'h2002, 8'h00);
        chk("R7 status read", int'(bus_rdata), 8'hE0);
        bus_op(1'b0, 16'h2002, 8'h00);
        chk("R7 bit7 cleared", int'(bus_rdata), 8'h60);

        // R7 status read resets the toggle between two scroll writes
        bus_op(1'b1, 16'h2005, 8'h01);
        chk("R3 first fine_x", int'(fine_x), 1);
        bus_op(1'b0, 16'h2002, 8'h00);
        bus_op(1'b1, 16'h2005, 8'h02);
        chk("R7 toggle reset", int'(fine_x), 2);
        bus_op(1'b0, 16'h2002, 8'h00);

        // R8 sprite pointer wrap and non-advancing reads
        bus_op(1'b1, 16'h2003, 8'hFE);
        bus_op(1'b1, 16'h2004, 8'hAA);
        bus_op(1'b1, 16'h2004, 8'hBB);
        bus_op(1'b1, 16'h2004, 8'hCC);
        bus_op(1'b1, 16'h2003, 8'hFF);
        bus_op(1'b0, 16'h2004, 8'h00);
        chk("R8 read at 0xFF", int'(bus_rdata), 8'hBB);
        bus_op(1'b0, 16'h2004, 8'h00);
        chk("R8 read no advance", int'(bus_rdata), 8'hBB);
        bus_op(1'b1, 16'h2003, 8'h00);
        bus_op(1'b0, 16'h200C, 8'h00);
        chk("R8 wrapped store at 0", int'(bus_rdata), 8'hCC);
        bus_op(1'b1, 16'h2003, 8'hFE);
        bus_op(1'b0, 16'h2004, 8'h00);
        chk("R8 store at 0xFE", int'(bus_rdata), 8'hAA);

        // R2 mask byte
        bus_op(1'b1, 16'h2001, 8'h1E);
        chk("R2 mask_q", int'(mask_q), 8'h1E);

        // R11 step by 32 across 0x3FFF
        bus_op(1'b1, 16'h2006, 8'h3F);
        bus_op(1'b1, 16'h2006, 8'hF0);
        chk("R6 cur load", int'(cur_addr), 15'h3FF0);
        bus_op(1'b1, 16'h2007, 8'h00);
        chk("R11 step 32", int'(cur_addr), 15'h4010);

        finish_run();
    end
endmodule